// File: doc/BRIEF.md
# Capability List Read Port

This block answers configuration reads that land in the capability window of a device header, from byte offset 0xA4 up to 0xFF. The capability list is described entirely by parameters: a count of capabilities and, for each one, an 8-bit identifier, a byte length and a row of data bytes. The block derives the layout from these parameters. Each capability starts on a 4-byte boundary directly after the padded extent of the one before it. The forward links are never stored; they are computed from that layout.

A read request carries a byte offset. One clock later the block returns a 32-bit word with a valid strobe. The word is assembled from the four bytes of the addressed doubleword of whichever capability owns the offset. A miss flag marks an offset that no capability covers, so the enclosing header logic can return zero for it. Writes and the fixed header registers belong to the surrounding logic.

Top module: `caplist_read_port`

## Requirements
- R1: The first capability begins at offset 0xA4; a read at 0xA4 returns that capability's identifier in bits 7:0.
- R2: Capability i occupies its length rounded up to a multiple of 4 bytes, and capability i+1 begins at the first byte after that rounded extent; lengths are taken from CAP_LENS[8*i +: 8].
- R3: Byte 0 of a capability reads as its identifier (CAP_IDS[8*i +: 8]), and byte 1 reads as the offset of the following capability, which is the current start plus the rounded length.
- R4: Byte 1 of the last capability reads as 0x00.
- R5: A byte whose position inside its capability is at or beyond the unrounded length (padding) reads as 0x00.
- R6: The word is little-endian: the byte at the lowest offset goes to bits 7:0 and the byte at offset+3 goes to bits 31:24. Byte p (p >= 2) of capability i comes from CAP_DATA[8*(i*MAX_LEN + p) +: 8].
- R7: An offset below 0xA4, or at or beyond the end of the last capability's rounded extent, sets rd_miss to 1 and rd_data to 0.
- R8: Bits 1:0 of rd_offset are ignored; the read always covers the aligned doubleword.
- R9: rd_valid is 1 in exactly the cycle after each cycle with rd_req high, and 0 otherwise. After reset rd_valid, rd_miss and rd_data are all 0.
- R10: rd_data and rd_miss change only in the cycle after a request; without a request they hold, whatever rd_offset does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_req | input | 1 | Read request for this cycle |
| rd_offset | input | 8 | Configuration byte offset of the read |
| rd_valid | output | 1 | Result of the previous cycle's request is present |
| rd_data | output | 32 | Assembled little-endian word, 0 on a miss |
| rd_miss | output | 1 | Offset lies outside every capability |

## Verification
The assertions check the following on every cycle: the strobe timing, the holding of the outputs between requests, and zero data on a miss. They also check that at most one capability claims an offset, that every miss lies outside the list's span, and that every forward link is aligned and points past the current read. The actual byte contents can only be shown by the bench scenarios, which compare each word against an independent walk of the parameter table. This covers the identifier and link bytes, the padding zeros, the zero link on the last entry, the data bytes, and the byte order. The scenarios cover every doubleword of the list, the boundary offsets on both sides of it, unaligned offsets, back-to-back requests and random traffic.

// File: rtl/cap_pkg.sv
`timescale 1ns/1ps
package cap_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned WORD_BYTES = 4;
  localparam int unsigned SPAN_W = 10;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [SPAN_W-1:0] span_t;

  // Length padded up to the next doubleword boundary.
  function automatic span_t pad_to_dword(input byte_t len);
    span_t wide;
    wide = span_t'(len) + span_t'(3);
    return wide & ~span_t'(3);
  endfunction

  // Aligned doubleword offset of a byte offset.
  function automatic byte_t dword_of(input byte_t off);
    return {off[BYTE_W-1:2], 2'b00};
  endfunction

endpackage

// File: rtl/caplist_locator.sv
`timescale 1ns/1ps
module caplist_locator #(
  parameter int unsigned N_CAPS = 3,
  parameter int unsigned IDX_W = 2,
  parameter logic [7:0] LIST_BASE = 8'hA4,
  parameter logic [N_CAPS*8-1:0] CAP_IDS = '0,
  parameter logic [N_CAPS*8-1:0] CAP_LENS = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       word_addr,
  output logic             hit,
  output logic [IDX_W-1:0] hit_idx,
  output logic [7:0]       hit_rel,
  output logic [7:0]       hit_len,
  output logic [7:0]       hit_id,
  output logic [7:0]       hit_next
);
  import cap_pkg::*;

  // Start offset of capability k: list base plus padded lengths before it.
  function automatic span_t start_of(input int unsigned k);
    span_t acc;
    acc = span_t'(LIST_BASE);
    for (int unsigned j = 0; j < k; j++) acc = acc + pad_to_dword(CAP_LENS[j*8 +: 8]);
    return acc;
  endfunction

  localparam span_t LIST_END = start_of(N_CAPS);

  logic [N_CAPS-1:0] match_vec;
  span_t             start_vec [N_CAPS];
  span_t             limit_vec [N_CAPS];
  span_t             addr_w;
  span_t             sel_start;
  span_t             sel_limit;
  logic              sel_last;

  assign addr_w = span_t'(word_addr);

  for (genvar gi = 0; gi < N_CAPS; gi++) begin : g_region
    localparam span_t START = start_of(gi);
    localparam span_t LIMIT = START + pad_to_dword(CAP_LENS[gi*8 +: 8]);
    assign start_vec[gi] = START;
    assign limit_vec[gi] = LIMIT;
    assign match_vec[gi] = (addr_w >= START) && (addr_w < LIMIT);
  end

  always_comb begin
    hit       = 1'b0;
    hit_idx   = '0;
    sel_start = '0;
    sel_limit = '0;
    sel_last  = 1'b0;
    hit_len   = '0;
    hit_id    = '0;
    for (int unsigned i = 0; i < N_CAPS; i++) begin
      if (match_vec[i] && !hit) begin
        hit       = 1'b1;
        hit_idx   = IDX_W'(i);
        sel_start = start_vec[i];
        sel_limit = limit_vec[i];
        sel_last  = (i == N_CAPS - 1);
        hit_len   = CAP_LENS[i*8 +: 8];
        hit_id    = CAP_IDS[i*8 +: 8];
      end
    end
  end

  span_t rel_w;
  assign rel_w    = addr_w - sel_start;
  assign hit_rel  = rel_w[7:0];
  assign hit_next = (hit && !sel_last) ? sel_limit[7:0] : 8'h00;

  // R2: padded regions never overlap, so at most one capability owns an offset
  a_r2_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec));

  // R7: a miss only happens outside the span of the whole list
  a_r7_miss_outside: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (addr_w < span_t'(LIST_BASE)) || (addr_w >= LIST_END));

  // R3: a forward link is doubleword aligned and lies past the current read
  a_r3_link_forward: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && hit_next != 8'h00) |-> (hit_next[1:0] == 2'b00) && (hit_next > word_addr));

endmodule

// File: rtl/caplist_lane.sv
`timescale 1ns/1ps
module caplist_lane #(
  parameter int unsigned N_CAPS = 3,
  parameter int unsigned IDX_W = 2,
  parameter int unsigned MAX_LEN = 12,
  parameter int unsigned LANE = 0,
  parameter logic [N_CAPS*MAX_LEN*8-1:0] CAP_DATA = '0
) (
  input  logic             hit,
  input  logic [IDX_W-1:0] hit_idx,
  input  logic [7:0]       hit_rel,
  input  logic [7:0]       hit_len,
  input  logic [7:0]       hit_id,
  input  logic [7:0]       hit_next,
  output logic [7:0]       lane_byte
);
  localparam int unsigned TOTAL_BYTES = N_CAPS * MAX_LEN;

  logic [7:0] pos;
  int unsigned flat;

  assign pos = hit_rel + 8'(LANE);

  always_comb begin
    flat = int'(hit_idx) * MAX_LEN + int'(pos);
    if (!hit || pos >= hit_len) lane_byte = 8'h00;
    else if (pos == 8'd0)       lane_byte = hit_id;
    else if (pos == 8'd1)       lane_byte = hit_next;
    else if (flat < TOTAL_BYTES) lane_byte = CAP_DATA[flat*8 +: 8];
    else                        lane_byte = 8'h00;
  end

endmodule

// File: rtl/caplist_read_port.sv
`timescale 1ns/1ps
module caplist_read_port #(
  parameter int unsigned N_CAPS = 3,
  parameter int unsigned MAX_LEN = 12,
  parameter logic [7:0] LIST_BASE = 8'hA4,
  parameter logic [N_CAPS*8-1:0] CAP_IDS = {8'h11, 8'h05, 8'h09},
  parameter logic [N_CAPS*8-1:0] CAP_LENS = {8'd12, 8'd10, 8'd5},
  parameter logic [N_CAPS*MAX_LEN*8-1:0] CAP_DATA = {(N_CAPS*MAX_LEN){8'h5A}}
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rd_req,
  input  logic [7:0]  rd_offset,
  output logic        rd_valid,
  output logic [31:0] rd_data,
  output logic        rd_miss
);
  import cap_pkg::*;

  localparam int unsigned IDX_W = (N_CAPS > 1) ? $clog2(N_CAPS) : 1;

  logic [7:0]       word_addr;
  logic             hit;
  logic [IDX_W-1:0] hit_idx;
  logic [7:0]       hit_rel;
  logic [7:0]       hit_len;
  logic [7:0]       hit_id;
  logic [7:0]       hit_next;
  logic [31:0]      word_asm;

  assign word_addr = dword_of(rd_offset);

  caplist_locator #(
    .N_CAPS(N_CAPS), .IDX_W(IDX_W), .LIST_BASE(LIST_BASE),
    .CAP_IDS(CAP_IDS), .CAP_LENS(CAP_LENS)
  ) u_locate (
    .clk(clk), .rst_n(rst_n), .word_addr(word_addr),
    .hit(hit), .hit_idx(hit_idx), .hit_rel(hit_rel),
    .hit_len(hit_len), .hit_id(hit_id), .hit_next(hit_next)
  );

  for (genvar gl = 0; gl < WORD_BYTES; gl++) begin : g_lane
    caplist_lane #(
      .N_CAPS(N_CAPS), .IDX_W(IDX_W), .MAX_LEN(MAX_LEN),
      .LANE(gl), .CAP_DATA(CAP_DATA)
    ) u_lane (
      .hit(hit), .hit_idx(hit_idx), .hit_rel(hit_rel),
      .hit_len(hit_len), .hit_id(hit_id), .hit_next(hit_next),
      .lane_byte(word_asm[gl*8 +: 8])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      rd_miss  <= 1'b0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) begin
        rd_data <= hit ? word_asm : 32'h0;
        rd_miss <= !hit;
      end
    end
  end

  // R9: every request yields a strobe one cycle later
  a_r9_strobe_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid);

  // R9: no strobe without a request
  a_r9_no_spurious_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rd_valid);

  // R10: outputs hold while no request is taken
  a_r10_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> $stable(rd_data) && $stable(rd_miss));

  // R7: a miss always reports zero data
  a_r7_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_miss) |-> (rd_data == 32'h0));

  // R1: nothing below the list base is ever answered as a hit
  a_r1_below_base_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_offset < LIST_BASE) |=> rd_miss);

endmodule

// File: tb/sim_caplist_read_port.sv
`timescale 1ns/1ps
module sim_caplist_read_port;

  localparam int NC = 3;
  localparam int ML = 12;
  localparam logic [NC*8-1:0] T_IDS  = {8'h11, 8'h05, 8'h09};
  localparam logic [NC*8-1:0] T_LENS = {8'd12, 8'd10, 8'd5};

  function automatic logic [NC*ML*8-1:0] make_data();
    logic [NC*ML*8-1:0] v;
    for (int k = 0; k < NC*ML; k++) v[k*8 +: 8] = 8'((k * 37 + 11) & 255);
    return v;
  endfunction

  localparam logic [NC*ML*8-1:0] T_DATA = make_data();

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_req = 1'b0;
  logic [7:0]  rd_offset = 8'h00;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic        rd_miss;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  caplist_read_port #(
    .N_CAPS(NC), .MAX_LEN(ML), .LIST_BASE(8'hA4),
    .CAP_IDS(T_IDS), .CAP_LENS(T_LENS), .CAP_DATA(T_DATA)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_offset(rd_offset),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_miss(rd_miss)
  );

  // Independent walk of the table: {miss, word}
  function automatic logic [32:0] expect_word(input logic [7:0] off);
    int a, start, padded, len, p;
    logic [31:0] w;
    logic [7:0] b;
    a = int'(off) & 'hFC;
    start = 'hA4;
    for (int i = 0; i < NC; i++) begin
      len = int'(T_LENS[i*8 +: 8]);
      padded = ((len + 3) / 4) * 4;
      if (a >= start && a < start + padded) begin
        w = 32'h0;
        for (int k = 0; k < 4; k++) begin
          p = a - start + k;
          if (p >= len) b = 8'h00;
          else if (p == 0) b = T_IDS[i*8 +: 8];
          else if (p == 1) b = (i == NC - 1) ? 8'h00 : 8'(start + padded);
          else b = T_DATA[(i*ML + p)*8 +: 8];
          w[k*8 +: 8] = b;
        end
        return {1'b0, w};
      end
      start = start + padded;
    end
    return {1'b1, 32'h0};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic        prev_req = 1'b0;
  logic [7:0]  prev_off = 8'h00;
  logic [32:0] held = 33'h0;

  // Drive one cycle, then at the next falling edge check the result of it.
  task automatic step(input logic req, input logic [7:0] off, input string tag);
    logic [32:0] e;
    @(negedge clk);
    rd_req = req;
    rd_offset = off;
    prev_req = req;
    prev_off = off;
    @(negedge clk);
    rd_req = 1'b0;
    check({tag, " R9 strobe"}, 64'(rd_valid), 64'(prev_req));
    if (prev_req) begin
      e = expect_word(prev_off);
      held = e;
    end else e = held;
    check(tag, {31'h0, rd_miss, rd_data}, {31'h0, e});
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [32:0] e;
    void'($urandom(32'h1234_5678));
    repeat (3) @(negedge clk);
    check("R9 reset valid", 64'(rd_valid), 64'h0);
    check("R9 reset data", {31'h0, rd_miss, rd_data}, 64'h0);
    rst_n = 1'b1;

    step(1'b1, 8'hA4, "R1 first cap");
    check("R1 id byte", 64'(rd_data[7:0]), 64'h09);
    check("R3 next link", 64'(rd_data[15:8]), 64'hAC);
    step(1'b1, 8'hA8, "R5 pad after len5");
    check("R5 padding zero", 64'(rd_data[31:8]), 64'h0);
    step(1'b1, 8'hAC, "R2 second start");
    check("R2 second id", 64'(rd_data[7:0]), 64'h05);
    check("R3 second link", 64'(rd_data[15:8]), 64'hB8);
    step(1'b1, 8'hB0, "R6 data bytes");
    e = expect_word(8'hB0);
    check("R6 byte order", 64'(rd_data[31:24]), 64'(T_DATA[(1*ML + 7)*8 +: 8]));
    step(1'b1, 8'hB4, "R5 tail pad");
    check("R5 bytes 10,11 zero", 64'(rd_data[31:16]), 64'h0);
    step(1'b1, 8'hB8, "R4 last cap");
    check("R4 last link zero", 64'(rd_data[15:8]), 64'h00);
    check("R3 last id", 64'(rd_data[7:0]), 64'h11);
    step(1'b1, 8'hC0, "R6 last data");
    step(1'b1, 8'hC4, "R7 end of list");
    check("R7 miss at end", 64'(rd_miss), 64'h1);
    step(1'b1, 8'hFC, "R7 top of window");
    step(1'b1, 8'hA0, "R7 below base");
    check("R7 miss below", 64'(rd_miss), 64'h1);
    step(1'b1, 8'hA7, "R8 unaligned");
    check("R8 same as A4", 64'(rd_data), 64'(expect_word(8'hA4)));
    step(1'b1, 8'hB9, "R8 unaligned last");
    step(1'b0, 8'hC4, "R10 idle offset change");
    step(1'b0, 8'hAC, "R10 idle again");

    // back-to-back requests
    @(negedge clk);
    rd_req = 1'b1; rd_offset = 8'hAC;
    @(negedge clk);
    rd_offset = 8'hC8;
    check("R9 b2b first valid", 64'(rd_valid), 64'h1);
    check("R2 b2b first data", {31'h0, rd_miss, rd_data}, {31'h0, expect_word(8'hAC)});
    @(negedge clk);
    rd_req = 1'b0;
    check("R9 b2b second valid", 64'(rd_valid), 64'h1);
    check("R7 b2b second data", {31'h0, rd_miss, rd_data}, {31'h0, expect_word(8'hC8)});
    held = expect_word(8'hC8);

    // constrained random traffic over and around the window
    for (int n = 0; n < 300; n++) begin
      logic r;
      logic [7:0] o;
      r = ($urandom % 4) != 0;
      o = 8'(8'h90 + ($urandom % 112));
      step(r, o, "R6 R7 random");
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule